// File: doc/BRIEF.md
# External Debug Register Access Gate

This block sits on the external debug bus in front of the debug and performance-monitor register windows. For every access it decides whether the access goes through normally, completes as read-as-zero with writes ignored, or completes with a slave error. The decision depends on the offset, the window, the access size, a reserved-offset flag from the address decoder, the state of the core power domain, the double lock, the OS lock, and the two external access enables. Error conditions are tested in a fixed order: lock and power state first, then the external debug enable, then the external PMU enable. Each level applies only to its own offset spans.

The block also holds a small set of clear-on-read status bits at one offset in the debug window. Event pulses set these bits, and a normal read returns and clears them. The clear is suppressed while the core domain is powered and the double lock is set. Every other register's contents live outside the block. The block gives them a one-cycle write-enable strobe and an offset.

The handshake follows APB timing. An access presented while the block is idle is accepted at a clock edge. The response (ready, error, zero-data override and read data) is valid for exactly the next cycle. A two-state machine controls this. In ST_IDLE the block waits for a request, and the transition *accept* (request valid) leads to ST_RESP. ST_RESP drives the response and always takes the transition *complete* back to ST_IDLE.

Top module: `dbg_access_gate`

## Requirements
- R1: A reserved access (`req_reserved`=1) gets `rsp_error`=1 when three things hold. The offset is in the lock span (debug window 0x000..0xCFC, PMU window 0x000..0xF00). At least one of these is true: `core_pwr_acc`=0, `dbl_lock`=1 or `os_lock`=1. An error response also has `rsp_zero`=1, `rsp_rdata`=0 and no `reg_wen`.
- R2: A reserved debug-window access not caught by R1 gets an error if its offset is in 0x400..0x4FC or 0x800..0x8FC and `ext_dbg_en`=0.
- R3: A reserved PMU-window access not caught by R1 gets an error if its offset is in 0x000..0x0FC or 0x400..0x47C and `ext_pmu_en`=0.
- R4: A reserved access that meets none of the error conditions completes with no error, `rsp_zero`=1, `rsp_rdata`=0 and no `reg_wen`.
- R5: A non-reserved access completes as zero-data with no error and no write strobe in two cases. One is an access whose size is not a word (`req_size` 2'b10). The other is a doubleword (2'b11) while `dword_ok`=0. Bytes (2'b00) and halfwords (2'b01) are always rejected. A doubleword with `dword_ok`=1 is normal.
- R6: A non-reserved, correctly sized write while `tgt_in_reset`=1 raises no `reg_wen`, no error, and sets `rsp_zero`=1.
- R7: A normal write raises `reg_wen` for exactly the response cycle, with `reg_offset` equal to the accepted offset. A normal access has `rsp_zero`=0 and `rsp_error`=0.
- R8: An access accepted in ST_IDLE raises `rsp_ready` for exactly the following cycle. Requests presented during ST_RESP are ignored.
- R9: Each `sticky_evt` bit sets its status bit. A normal word read of offset STAT_OFF (0x314) in the debug window (`req_pmu`=0) returns the bits in `rsp_rdata[STAT_W-1:0]` and then clears them.
- R10: A status read accepted while `core_pwr_acc`=1 and `dbl_lock`=1 returns the bits but does not clear them.
- R11: After reset the block is in ST_IDLE, `rsp_ready` and `reg_wen` are 0, and all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access presented |
| req_write | input | 1 | 1 = write, 0 = read |
| req_pmu | input | 1 | Window select: 0 = debug, 1 = PMU |
| req_offset | input | OFF_W | Byte offset within the window |
| req_size | input | 2 | 00 byte, 01 half, 10 word, 11 doubleword |
| req_reserved | input | 1 | Offset decodes to no implemented register |
| core_pwr_acc | input | 1 | Core power domain on and accessible |
| dbl_lock | input | 1 | OS double lock set |
| os_lock | input | 1 | OS lock set |
| ext_dbg_en | input | 1 | External debug access allowed |
| ext_pmu_en | input | 1 | External PMU access allowed |
| dword_ok | input | 1 | Doubleword accesses permitted |
| tgt_in_reset | input | 1 | Target register is held in reset |
| sticky_evt | input | STAT_W | Set pulses for the status bits |
| rsp_ready | output | 1 | Response valid this cycle |
| rsp_error | output | 1 | Slave error response |
| rsp_zero | output | 1 | Read data forced to zero |
| rsp_rdata | output | DATA_W | Read data from the status bits |
| reg_wen | output | 1 | Write strobe to the register file |
| reg_offset | output | OFF_W | Offset for the write strobe |

## Verification
The assertions assume a requester that presents one access and then waits for `rsp_ready` before the next one. They also assume that the lock and enable inputs stay stable from acceptance to completion. The hold-on-read check relies on the hold condition being captured when the access is accepted. The bench drives every input on the falling edge and drops `req_valid` right after acceptance. The one exception is a deliberate case that holds `req_valid` through ST_RESP to show that such a request is ignored. The status-bit checks pulse `sticky_evt` only between accesses, so no set coincides with a clear.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;

    typedef enum logic [1:0] {
        ACC_OK   = 2'd0,
        ACC_RAZ  = 2'd1,
        ACC_ERR  = 2'd2,
        ACC_DROP = 2'd3
    } acc_kind_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } gate_state_t;

    localparam logic [1:0] SZ_WORD  = 2'b10;
    localparam logic [1:0] SZ_DWORD = 2'b11;

    function automatic logic in_span(input logic [15:0] a,
                                     input logic [15:0] lo,
                                     input logic [15:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/dbg_gate_classify.sv
module dbg_gate_classify
    import dbg_gate_pkg::*;
#(
    parameter int          OFF_W       = 12,
    parameter logic [15:0] DBG_LOCK_HI = 16'h0CFC,
    parameter logic [15:0] PMU_LOCK_HI = 16'h0F00,
    parameter logic [15:0] DBG_EN_A_LO = 16'h0400,
    parameter logic [15:0] DBG_EN_A_HI = 16'h04FC,
    parameter logic [15:0] DBG_EN_B_LO = 16'h0800,
    parameter logic [15:0] DBG_EN_B_HI = 16'h08FC,
    parameter logic [15:0] PMU_EN_A_LO = 16'h0000,
    parameter logic [15:0] PMU_EN_A_HI = 16'h00FC,
    parameter logic [15:0] PMU_EN_B_LO = 16'h0400,
    parameter logic [15:0] PMU_EN_B_HI = 16'h047C
) (
    input  logic             pmu,
    input  logic [OFF_W-1:0] offset,
    input  logic [1:0]       size,
    input  logic             write,
    input  logic             reserved,
    input  logic             pwr_acc,
    input  logic             dbl_lock,
    input  logic             os_lock,
    input  logic             ext_dbg_en,
    input  logic             ext_pmu_en,
    input  logic             dword_ok,
    input  logic             tgt_in_reset,
    output acc_kind_t        kind
);

    localparam logic [15:0] SPAN_BASE = 16'h0000;

    logic [15:0] addr;
    logic        lock_blk;
    logic        lock_hit;
    logic        dbg_en_hit;
    logic        pmu_en_hit;
    logic        size_ok;

    assign addr = 16'(offset);

    always_comb begin
        lock_blk   = !pwr_acc || dbl_lock || os_lock;
        lock_hit   = pmu ? in_span(addr, SPAN_BASE, PMU_LOCK_HI)
                         : in_span(addr, SPAN_BASE, DBG_LOCK_HI);
        dbg_en_hit = !pmu && (in_span(addr, DBG_EN_A_LO, DBG_EN_A_HI) ||
                              in_span(addr, DBG_EN_B_LO, DBG_EN_B_HI));
        pmu_en_hit =  pmu && (in_span(addr, PMU_EN_A_LO, PMU_EN_A_HI) ||
                              in_span(addr, PMU_EN_B_LO, PMU_EN_B_HI));
        size_ok    = (size == SZ_WORD) || ((size == SZ_DWORD) && dword_ok);

        kind = ACC_OK;
        if (reserved) begin
            // layered order: lock/power, then debug enable, then PMU enable
            if (lock_hit && lock_blk)
                kind = ACC_ERR;
            else if (dbg_en_hit && !ext_dbg_en)
                kind = ACC_ERR;
            else if (pmu_en_hit && !ext_pmu_en)
                kind = ACC_ERR;
            else
                kind = ACC_RAZ;
        end else if (!size_ok) begin
            kind = ACC_RAZ;
        end else if (write && tgt_in_reset) begin
            kind = ACC_DROP;
        end
    end

endmodule

// File: rtl/dbg_gate_ctrl.sv
module dbg_gate_ctrl
    import dbg_gate_pkg::*;
#(
    parameter int OFF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [OFF_W-1:0] req_offset,
    input  acc_kind_t        kind_in,
    input  logic             stat_hit,
    input  logic             hold_in,
    output logic             rsp_ready,
    output logic             rsp_error,
    output logic             rsp_zero,
    output logic             reg_wen,
    output logic [OFF_W-1:0] reg_offset,
    output logic             stat_rd,
    output logic             hold_q
);

    gate_state_t      state_q;
    gate_state_t      state_d;
    acc_kind_t        kind_q;
    logic             wr_q;
    logic             hit_q;
    logic [OFF_W-1:0] off_q;
    logic             accept;

    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign reg_offset = off_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept (IDLE->RESP), complete (RESP->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // access capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= ACC_OK;
            wr_q   <= 1'b0;
            hit_q  <= 1'b0;
            off_q  <= '0;
            hold_q <= 1'b0;
        end else if (accept) begin
            kind_q <= kind_in;
            wr_q   <= req_write;
            hit_q  <= stat_hit;
            off_q  <= req_offset;
            hold_q <= hold_in;
        end
    end

    // outputs
    always_comb begin
        rsp_ready = 1'b0;
        rsp_error = 1'b0;
        rsp_zero  = 1'b0;
        reg_wen   = 1'b0;
        stat_rd   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                rsp_ready = 1'b1;
                rsp_error = (kind_q == ACC_ERR);
                rsp_zero  = (kind_q != ACC_OK);
                reg_wen   = (kind_q == ACC_OK) && wr_q;
                stat_rd   = (kind_q == ACC_OK) && !wr_q && hit_q;
            end
            default: ;
        endcase
    end

    AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESP) |=> (state_q == ST_IDLE)); // R8
    AST_ACCEPT_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_ready); // R8
    AST_WEN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wen |-> (rsp_ready && !rsp_error && !rsp_zero)); // R7
    AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> (rsp_zero && !reg_wen)); // R1

endmodule

// File: rtl/dbg_gate_sticky.sv
module dbg_gate_sticky #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_stb,
    input  logic         hold,
    output logic [W-1:0] value
);

    logic do_clr;
    assign do_clr = clr_stb && !hold;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) value[i] <= 1'b0;
            else        value[i] <= (value[i] && !do_clr) || evt[i];
        end
    end

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && hold) |=> ((value & $past(value)) == $past(value))); // R10
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !hold && (evt == '0)) |=> (value == '0)); // R9

endmodule

// File: rtl/dbg_access_gate.sv
module dbg_access_gate
    import dbg_gate_pkg::*;
#(
    parameter int               OFF_W    = 12,
    parameter int               DATA_W   = 32,
    parameter int               STAT_W   = 8,
    parameter logic [OFF_W-1:0] STAT_OFF = 12'h314
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_pmu,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [1:0]        req_size,
    input  logic              req_reserved,
    input  logic              core_pwr_acc,
    input  logic              dbl_lock,
    input  logic              os_lock,
    input  logic              ext_dbg_en,
    input  logic              ext_pmu_en,
    input  logic              dword_ok,
    input  logic              tgt_in_reset,
    input  logic [STAT_W-1:0] sticky_evt,
    output logic              rsp_ready,
    output logic              rsp_error,
    output logic              rsp_zero,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              reg_wen,
    output logic [OFF_W-1:0]  reg_offset
);

    localparam int PAD_W = DATA_W - STAT_W;

    acc_kind_t         kind;
    logic              stat_hit;
    logic              hold_in;
    logic              hold_q;
    logic              stat_rd;
    logic [STAT_W-1:0] stat_val;

    assign stat_hit = !req_pmu && (req_offset == STAT_OFF);
    assign hold_in  = core_pwr_acc && dbl_lock;

    dbg_gate_classify #(.OFF_W(OFF_W)) u_classify (
        .pmu          (req_pmu),
        .offset       (req_offset),
        .size         (req_size),
        .write        (req_write),
        .reserved     (req_reserved),
        .pwr_acc      (core_pwr_acc),
        .dbl_lock     (dbl_lock),
        .os_lock      (os_lock),
        .ext_dbg_en   (ext_dbg_en),
        .ext_pmu_en   (ext_pmu_en),
        .dword_ok     (dword_ok),
        .tgt_in_reset (tgt_in_reset),
        .kind         (kind)
    );

    dbg_gate_ctrl #(.OFF_W(OFF_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_offset (req_offset),
        .kind_in    (kind),
        .stat_hit   (stat_hit),
        .hold_in    (hold_in),
        .rsp_ready  (rsp_ready),
        .rsp_error  (rsp_error),
        .rsp_zero   (rsp_zero),
        .reg_wen    (reg_wen),
        .reg_offset (reg_offset),
        .stat_rd    (stat_rd),
        .hold_q     (hold_q)
    );

    dbg_gate_sticky #(.W(STAT_W)) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (sticky_evt),
        .clr_stb (stat_rd),
        .hold    (hold_q),
        .value   (stat_val)
    );

    assign rsp_rdata = stat_rd ? {{PAD_W{1'b0}}, stat_val} : '0;

    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> (rsp_rdata == '0)); // R1
    AST_ZERO_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_zero |-> (rsp_rdata == '0)); // R4
    AST_DATA_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_rdata != '0) |-> rsp_ready); // R9

endmodule

// File: tb/tb_dbg_access_gate.sv
module tb_dbg_access_gate;

    localparam int OFF_W  = 12;
    localparam int DATA_W = 32;
    localparam int STAT_W = 8;
    localparam logic [OFF_W-1:0] STAT_OFF = 12'h314;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0, req_pmu = 1'b0;
    logic [OFF_W-1:0]  req_offset = '0;
    logic [1:0]        req_size = 2'b10;
    logic              req_reserved = 1'b0;
    logic              core_pwr_acc = 1'b1, dbl_lock = 1'b0, os_lock = 1'b0;
    logic              ext_dbg_en = 1'b1, ext_pmu_en = 1'b1;
    logic              dword_ok = 1'b0, tgt_in_reset = 1'b0;
    logic [STAT_W-1:0] sticky_evt = '0;
    logic              rsp_ready, rsp_error, rsp_zero, reg_wen;
    logic [DATA_W-1:0] rsp_rdata;
    logic [OFF_W-1:0]  reg_offset;

    always #5 clk = ~clk;

    dbg_access_gate #(.OFF_W(OFF_W), .DATA_W(DATA_W), .STAT_W(STAT_W), .STAT_OFF(STAT_OFF)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_pmu(req_pmu), .req_offset(req_offset), .req_size(req_size),
        .req_reserved(req_reserved), .core_pwr_acc(core_pwr_acc), .dbl_lock(dbl_lock),
        .os_lock(os_lock), .ext_dbg_en(ext_dbg_en), .ext_pmu_en(ext_pmu_en),
        .dword_ok(dword_ok), .tgt_in_reset(tgt_in_reset), .sticky_evt(sticky_evt),
        .rsp_ready(rsp_ready), .rsp_error(rsp_error), .rsp_zero(rsp_zero),
        .rsp_rdata(rsp_rdata), .reg_wen(reg_wen), .reg_offset(reg_offset)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic              o_ready, o_err, o_zero, o_wen, o_after;
    logic [DATA_W-1:0] o_rdata;
    logic [OFF_W-1:0]  o_off;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one access: present, sample the response cycle, sample the idle cycle after
    task automatic access(input logic w, input logic pmu, input logic [OFF_W-1:0] off,
                          input logic [1:0] sz, input logic res);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_pmu = pmu;
        req_offset = off; req_size = sz; req_reserved = res;
        @(negedge clk);
        req_valid = 1'b0;
        o_ready = rsp_ready; o_err = rsp_error; o_zero = rsp_zero;
        o_wen = reg_wen; o_rdata = rsp_rdata; o_off = reg_offset;
        @(negedge clk);
        o_after = rsp_ready;
    endtask

    // reference decision for reserved offsets: returns 0 none, 1/2/3 error level
    function automatic int err_level(input bit pmu, input int off, input bit pwr,
                                     input bit dl, input bit osl, input bit ed, input bit ep);
        bit lock_span, lock_on;
        lock_span = pmu ? (off <= 'hF00) : (off <= 'hCFC);
        lock_on   = !pwr || dl || osl;
        if (lock_span && lock_on) return 1;
        if (!pmu && !ed && ((off >= 'h400 && off <= 'h4FC) || (off >= 'h800 && off <= 'h8FC))) return 2;
        if (pmu && !ep && (off <= 'hFC || (off >= 'h400 && off <= 'h47C))) return 3;
        return 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int offs [18] = '{'h000, 'h0FC, 'h100, 'h3FC, 'h400, 'h47C, 'h480, 'h4FC, 'h500,
                          'h7FC, 'h800, 'h8FC, 'h900, 'hCFC, 'hD00, 'hF00, 'hF04, 'hFFC};
        repeat (3) @(negedge clk);
        check("R11 ready after reset", 32'(rsp_ready), 32'd0);
        check("R11 wen after reset", 32'(reg_wen), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 ready idle", 32'(rsp_ready), 32'd0);
        access(1'b0, 1'b0, STAT_OFF, 2'b10, 1'b0);
        check("R11 status zero after reset", o_rdata, 32'd0);

        // reserved-offset sweep over window, offset, lock/enable state, direction
        for (int p = 0; p < 2; p++) begin
            for (int oi = 0; oi < 18; oi++) begin
                for (int c = 0; c < 32; c++) begin
                    for (int w = 0; w < 2; w++) begin
                        int lvl;
                        string tg;
                        core_pwr_acc = c[0]; dbl_lock = c[1]; os_lock = c[2];
                        ext_dbg_en = c[3]; ext_pmu_en = c[4];
                        lvl = err_level(p[0], offs[oi], c[0], c[1], c[2], c[3], c[4]);
                        tg = (lvl == 1) ? "R1" : (lvl == 2) ? "R2" : (lvl == 3) ? "R3" : "R4";
                        access(w[0], p[0], OFF_W'(offs[oi]), 2'b10, 1'b1);
                        check($sformatf("%s err p=%0d off=%h c=%0d", tg, p, offs[oi], c),
                              32'(o_err), 32'(lvl != 0));
                        check($sformatf("%s zero", tg), 32'(o_zero), 32'd1);
                        check($sformatf("%s wen", tg), 32'(o_wen), 32'd0);
                        check($sformatf("%s rdata", tg), o_rdata, 32'd0);
                    end
                end
            end
        end
        core_pwr_acc = 1'b1; dbl_lock = 1'b0; os_lock = 1'b0;
        ext_dbg_en = 1'b1; ext_pmu_en = 1'b1;

        // size / reset-target sweep on a normal offset
        for (int sz = 0; sz < 4; sz++) begin
            for (int dw = 0; dw < 2; dw++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int ir = 0; ir < 2; ir++) begin
                        bit size_ok, drop, ok;
                        dword_ok = dw[0]; tgt_in_reset = ir[0];
                        size_ok = (sz == 2) || (sz == 3 && dw == 1);
                        drop = size_ok && w == 1 && ir == 1;
                        ok = size_ok && !drop;
                        access(w[0], 1'b0, 12'h100, 2'(sz), 1'b0);
                        check(size_ok ? (drop ? "R6 zero" : "R7 zero") : "R5 zero",
                              32'(o_zero), 32'(!ok));
                        check(size_ok ? "R6 err" : "R5 err", 32'(o_err), 32'd0);
                        check(ok ? "R7 wen" : (drop ? "R6 wen" : "R5 wen"),
                              32'(o_wen), 32'(ok && w == 1));
                        check("R8 ready in response", 32'(o_ready), 32'd1);
                        check("R8 ready drops", 32'(o_after), 32'd0);
                        if (ok && w == 1) check("R7 offset", 32'(o_off), 32'h100);
                    end
                end
            end
        end
        dword_ok = 1'b0; tgt_in_reset = 1'b0;

        // R8: a request held through the response cycle is ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_pmu = 1'b0; req_offset = 12'h040;
        req_size = 2'b10; req_reserved = 1'b0;
        @(negedge clk);
        req_offset = 12'h080;
        check("R8 first response", 32'(rsp_ready), 32'd1);
        check("R7 first offset", 32'(reg_offset), 32'h040);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 held request ignored ready", 32'(rsp_ready), 32'd0);
        check("R8 held request ignored wen", 32'(reg_wen), 32'd0);
        @(negedge clk);
        check("R8 still idle", 32'(rsp_ready), 32'd0);

        // R9: set, read, cleared
        @(negedge clk); sticky_evt = 8'h5A;
        @(negedge clk); sticky_evt = 8'h00;
        access(1'b0, 1'b0, STAT_OFF, 2'b10, 1'b0);
        check("R9 status read", o_rdata, 32'h5A);
        access(1'b0, 1'b0, STAT_OFF, 2'b10, 1'b0);
        check("R9 status cleared", o_rdata, 32'h00);
        access(1'b0, 1'b1, STAT_OFF, 2'b10, 1'b0);
        check("R9 pmu window not status", o_rdata, 32'h00);

        // R10: held while powered and double-locked
        @(negedge clk); sticky_evt = 8'h3C;
        @(negedge clk); sticky_evt = 8'h00;
        dbl_lock = 1'b1;
        access(1'b0, 1'b0, STAT_OFF, 2'b10, 1'b0);
        check("R10 status read locked", o_rdata, 32'h3C);
        access(1'b0, 1'b0, STAT_OFF, 2'b10, 1'b0);
        check("R10 status kept", o_rdata, 32'h3C);
        core_pwr_acc = 1'b0;
        access(1'b0, 1'b0, STAT_OFF, 2'b10, 1'b0);
        check("R9 read with power off", o_rdata, 32'h3C);
        core_pwr_acc = 1'b1; dbl_lock = 1'b0;
        access(1'b0, 1'b0, STAT_OFF, 2'b10, 1'b0);
        check("R9 cleared once unpowered read", o_rdata, 32'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule